// File: doc/BRIEF.md
# Multi-symbol CAVLC run_before decoder

This block turns the run_before part of one 4x4 residual block into zero-run values. At start it captures the number of zeros still to place (`total_zeros`) and the number of run symbols to decode (`num_runs`). It then walks the block in steps. Each step reads an 11-bit bit-stream window whose first unread bit is the MSB. While at most six zeros remain, one step decodes up to three run values through a single lookup. The lookup has three variants, chosen by how many symbols are left. Separate one-, two- and three-symbol lookups are needed because no bits are coded for runs once the zero budget is spent. An otherwise identical window can therefore mean two symbols plus the next syntax element, or three symbols. When more than six zeros remain, a step decodes one code from a long-code table.

Each step is offered on a valid/ready output. `out_valid` is high for the whole time a block is being decoded. A step is taken only in a cycle where `out_valid` and `out_ready` are both high. In that cycle the external shifter must advance the bit stream by `bits_used`. While `out_ready` is low the decoder holds its state, and the caller must hold `win` steady. The outputs then stay the same. `done` pulses once after the last step is taken.

Top module: `rb_multi_dec`

## Requirements
- R1: A `start` pulse while `out_valid` is low loads the zero budget from `total_zeros` and the symbol count from `num_runs`. A `start` while `out_valid` is high is ignored, and the running block continues unchanged.
- R2: While the zero budget is 6 or less, a step decodes min(symbols left, 3) values. `run_vld` then shows that many lanes from bit 0 upward (3'b001, 3'b011 or 3'b111). `run_vld` is 0 while `out_valid` is low.
- R3: While the zero budget exceeds 6, a step decodes exactly one value using the long codes: 111→0, 110→1, 101→2, 100→3, 011→4, 010→5, 001→6, 0001→7, and so on, ending with ten zeros then a one →14.
- R4: Short codes by zero budget:
  - 1: 1→0, 0→1.
  - 2: 1→0, 01→1, 00→2.
  - 3: 11→0, 10→1, 01→2, 00→3.
  - 4: 11→0, 10→1, 01→2, 001→3, 000→4.
  - 5: 11→0, 10→1, 011→2, 010→3, 001→4, 000→5.
  - 6: 11→0, 000→1, 001→2, 011→3, 010→4, 101→5, 100→6.

  Lane i of `run_vals` is bits [4i+3:4i], and lane 0 is decoded first.
- R5: `bits_used` is the total code length of the values in the current step. Each taken step lowers the zero budget by the sum of its values.
- R6: Window bits beyond the 8 leading bits (three-symbol step), the 6 leading bits (two-symbol step) or the 3 leading bits (one-symbol step) have no effect on the outputs.
- R7: Once the zero budget reaches 0, including partway through a step, every further value is 0 and takes no bits.
- R8: The decoder state advances only in a cycle with `out_valid` and `out_ready` both high. With `win` held, the outputs stay stable during a stall.
- R9: `done` is high for exactly one cycle, in the cycle after the final step is taken. With `num_runs` = 0 it is high in the cycle after `start`, and `out_valid` never rises.
- R10: `win[10]` is the first unread bit of the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a block (ignored while busy) |
| total_zeros | input | 4 | Initial zero budget |
| num_runs | input | 4 | Number of run symbols to decode |
| win | input | 11 | Bit-stream window, first bit at MSB |
| out_ready | input | 1 | Consumer accepts the current step |
| out_valid | output | 1 | A step is offered (block in progress) |
| run_vals | output | 12 | Three 4-bit run lanes, lane 0 at LSBs |
| run_vld | output | 3 | Per-lane valid for the current step |
| bits_used | output | 4 | Bits consumed by the current step |
| done | output | 1 | One-cycle pulse after the final step |

## Verification
Two things can coincide in one cycle: taking a step, including the last step of a block, and a `start` pulse arriving. The bench raises `start` with random block parameters in random busy cycles, under random `out_ready` back-pressure. It then judges that the outputs keep following the model of the first block, that `done` still appears exactly one cycle after the final step, and that no second block begins. A second coincidence is also exercised: the zero budget running out partway through a three-lane step, where some lanes must read 0 with no bits while the step as a whole is still taken.

// File: rtl/rb_pkg.sv
package rb_pkg;

  typedef struct packed {
    logic [3:0] run;
    logic [3:0] len;
  } code_t;

  // one short code, zero budget 0..6, b = next three stream bits (MSB first)
  function automatic code_t short_code(input logic [3:0] zl, input logic [2:0] b);
    code_t c;
    c = '0;
    case (zl)
      4'd1: begin c.len = 4'd1; c.run = b[2] ? 4'd0 : 4'd1; end
      4'd2: begin
        if (b[2]) begin c.len = 4'd1; c.run = 4'd0; end
        else begin c.len = 4'd2; c.run = b[1] ? 4'd1 : 4'd2; end
      end
      4'd3: begin c.len = 4'd2; c.run = 4'd3 - {2'b00, b[2:1]}; end
      4'd4: begin
        if (b[2] | b[1]) begin c.len = 4'd2; c.run = 4'd3 - {2'b00, b[2:1]}; end
        else begin c.len = 4'd3; c.run = b[0] ? 4'd3 : 4'd4; end
      end
      4'd5: begin
        if (b[2]) begin c.len = 4'd2; c.run = b[1] ? 4'd0 : 4'd1; end
        else begin c.len = 4'd3; c.run = 4'd5 - {1'b0, b}; end
      end
      4'd6: begin
        if (b[2:1] == 2'b11) begin c.len = 4'd2; c.run = 4'd0; end
        else begin
          c.len = 4'd3;
          case (b)
            3'b000:  c.run = 4'd1;
            3'b001:  c.run = 4'd2;
            3'b011:  c.run = 4'd3;
            3'b010:  c.run = 4'd4;
            3'b101:  c.run = 4'd5;
            default: c.run = 4'd6;
          endcase
        end
      end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/rb_long_dec.sv
module rb_long_dec (
  input  logic [10:0] win,
  output logic [3:0]  run,
  output logic [3:0]  len
);
  logic [3:0] hi_pos;
  logic       hit;

  always_comb begin
    hi_pos = '0;
    hit    = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (win[i]) begin
        hi_pos = 4'(i);
        hit    = 1'b1;
      end
    end
    if (win[10:8] != 3'b000) begin
      run = 4'd7 - {1'b0, win[10:8]};
      len = 4'd3;
    end else if (hit) begin
      run = 4'd14 - hi_pos;
      len = 4'd11 - hi_pos;
    end else begin
      run = 4'd0;
      len = 4'd11;
    end
  end
endmodule

// File: rtl/rb_group_lut.sv
module rb_group_lut
  import rb_pkg::*;
#(
  parameter int N   = 3,
  parameter int W   = 8,
  parameter int GRP = 3
) (
  input  logic [3:0]       zl,
  input  logic [W-1:0]     win,
  output logic [GRP*4-1:0] runs,
  output logic [3:0]       len
);
  localparam int PW = W + 3;

  logic [PW-1:0] pad;
  assign pad = {win, 3'b000};

  always_comb begin
    logic [3:0] z;
    int         off;
    code_t      c;
    runs = '0;
    z    = zl;
    off  = 0;
    for (int i = 0; i < N; i++) begin
      c = short_code(z, pad[PW-1-off -: 3]);
      runs[4*i +: 4] = c.run;
      off = off + int'(c.len);
      z   = z - c.run;
    end
    len = 4'(off);
  end
endmodule

// File: rtl/rb_ctrl.sv
module rb_ctrl #(
  parameter int ZL_W  = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ZL_W-1:0]  tz,
  input  logic [CNT_W-1:0] nr,
  input  logic             ready,
  input  logic [CNT_W-1:0] step_n,
  input  logic [ZL_W:0]    run_sum,
  output logic             busy,
  output logic [ZL_W-1:0]  zl_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             done_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      zl_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy) begin
        if (ready) begin
          zl_q  <= (run_sum >= {1'b0, zl_q}) ? '0 : zl_q - run_sum[ZL_W-1:0];
          cnt_q <= cnt_q - step_n;
          if (cnt_q == step_n) begin
            busy   <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end else if (start) begin
        zl_q   <= tz;
        cnt_q  <= nr;
        busy   <= (nr != '0);
        done_q <= (nr == '0);
      end
    end
  end
endmodule

// File: rtl/rb_multi_dec.sv
module rb_multi_dec #(
  parameter int ZL_W      = 4,
  parameter int WIN_W     = 11,
  parameter int GRP       = 3,
  parameter int MULTI_MAX = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ZL_W-1:0]    total_zeros,
  input  logic [ZL_W-1:0]    num_runs,
  input  logic [WIN_W-1:0]   win,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [GRP*4-1:0]   run_vals,
  output logic [GRP-1:0]     run_vld,
  output logic [3:0]         bits_used,
  output logic               done
);
  localparam int RV_W = GRP * 4;

  logic [ZL_W-1:0] zl_q;
  logic [ZL_W-1:0] cnt_q;
  logic [ZL_W-1:0] step_n;
  logic [ZL_W:0]   run_sum;
  logic            busy;

  logic [RV_W-1:0] tbl_runs [GRP];
  logic [3:0]      tbl_len  [GRP];
  logic [3:0]      long_run;
  logic [3:0]      long_len;

  // one lookup per symbol count; wider tables see more leading window bits
  for (genvar t = 0; t < GRP; t++) begin : g_tbl
    localparam int W = (t == 0) ? 3 : ((t == 1) ? 6 : 8);
    rb_group_lut #(.N(t + 1), .W(W), .GRP(GRP)) u_lut (
      .zl   (zl_q),
      .win  (win[WIN_W-1 -: W]),
      .runs (tbl_runs[t]),
      .len  (tbl_len[t])
    );
  end

  rb_long_dec u_long (
    .win (win[WIN_W-1 -: 11]),
    .run (long_run),
    .len (long_len)
  );

  always_comb begin
    logic [ZL_W-1:0] grp_n;
    grp_n = (cnt_q >= ZL_W'(GRP)) ? ZL_W'(GRP) : cnt_q;
    if (zl_q <= ZL_W'(MULTI_MAX)) begin
      step_n = grp_n;
      if (grp_n == '0) begin
        run_vals  = '0;
        bits_used = '0;
      end else begin
        run_vals  = tbl_runs[grp_n - 1'b1];
        bits_used = tbl_len[grp_n - 1'b1];
      end
    end else begin
      step_n    = ZL_W'(1);
      run_vals  = {{(RV_W-4){1'b0}}, long_run};
      bits_used = long_len;
    end
    run_sum = '0;
    for (int i = 0; i < GRP; i++) begin
      run_sum = run_sum + {1'b0, run_vals[4*i +: 4]};
    end
    for (int i = 0; i < GRP; i++) begin
      run_vld[i] = busy && (ZL_W'(i) < step_n);
    end
  end

  rb_ctrl #(.ZL_W(ZL_W), .CNT_W(ZL_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .tz      (total_zeros),
    .nr      (num_runs),
    .ready   (out_ready),
    .step_n  (step_n),
    .run_sum (run_sum),
    .busy    (busy),
    .zl_q    (zl_q),
    .cnt_q   (cnt_q),
    .done_q  (done)
  );

  assign out_valid = busy;
endmodule

// File: rtl/rb_multi_dec_chk.sv
module rb_multi_dec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        out_ready,
  input logic        out_valid,
  input logic [2:0]  run_vld,
  input logic [3:0]  bits_used,
  input logic        done,
  input logic [3:0]  zl_q,
  input logic [3:0]  cnt_q
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(zl_q) && $stable(cnt_q)); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && start && out_ready |=> cnt_q < $past(cnt_q)); // R1
  AST_VLD_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (run_vld == 3'b001 || run_vld == 3'b011 || run_vld == 3'b111)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> run_vld == 3'b000); // R2
  AST_LONG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && zl_q > 4'd6 |-> run_vld == 3'b001); // R3
  AST_GROUP_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && run_vld[1] |-> bits_used <= 4'd8); // R6
  AST_ZL_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> zl_q <= $past(zl_q)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid); // R9
endmodule

bind rb_multi_dec rb_multi_dec_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .run_vld   (run_vld),
  .bits_used (bits_used),
  .done      (done),
  .zl_q      (zl_q),
  .cnt_q     (cnt_q)
);

// File: tb/rb_multi_dec_tb_top.sv
module rb_multi_dec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  tz_i = '0;
  logic [3:0]  nr_i = '0;
  logic [10:0] win = '0;
  logic        out_ready = 1'b0;
  logic        out_valid;
  logic [11:0] run_vals;
  logic [2:0]  run_vld;
  logic [3:0]  bits_used;
  logic        done;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [127:0] stream;
  int drn [16];

  rb_multi_dec dut_i (
    .clk (clk), .rst_n (rst_n), .start (start),
    .total_zeros (tz_i), .num_runs (nr_i), .win (win),
    .out_ready (out_ready), .out_valid (out_valid), .run_vals (run_vals),
    .run_vld (run_vld), .bits_used (bits_used), .done (done)
  );

  always #5 clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R9 watchdog: actual=no finish expected=finish by cycle 150000");
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int enc_len(input int zl, input int run);
    if (zl > 6) return (run < 7) ? 3 : run - 3;
    case (zl)
      1: return 1;
      2: return (run == 0) ? 1 : 2;
      3: return 2;
      4: return (run < 3) ? 2 : 3;
      5: return (run < 2) ? 2 : 3;
      default: return (run == 0) ? 2 : 3;
    endcase
  endfunction

  function automatic int enc_code(input int zl, input int run);
    if (zl > 6) return (run < 7) ? 7 - run : 1;
    case (zl)
      1: return (run == 0) ? 1 : 0;
      2: return (run == 0) ? 1 : ((run == 1) ? 1 : 0);
      3: return 3 - run;
      4: return (run < 3) ? 3 - run : ((run == 3) ? 1 : 0);
      5: return (run < 2) ? 3 - run : 5 - run;
      default: begin
        case (run)
          0: return 3;
          1: return 0;
          2: return 1;
          3: return 3;
          4: return 2;
          5: return 5;
          default: return 4;
        endcase
      end
    endcase
  endfunction

  // lay the block's codes at the top of a random stream (garbage follows)
  task automatic build(input int tz, input int nr, input bit rnd);
    int zl;
    int pos;
    stream = {$urandom, $urandom, $urandom, $urandom};
    zl = tz;
    pos = 0;
    for (int i = 0; i < nr; i++) begin
      if (rnd) drn[i] = (zl == 0) ? 0 : int'($urandom % (zl + 1));
      if (zl == 0) drn[i] = 0;
      if (zl > 0) begin
        int l;
        int c;
        l = enc_len(zl, drn[i]);
        c = enc_code(zl, drn[i]);
        for (int b = l - 1; b >= 0; b--) begin
          stream[127 - pos] = c[b];
          pos++;
        end
      end
      zl = zl - drn[i];
    end
  endtask

  task automatic run_block(input int tz, input int nr, input string bits_tag, input bit noise);
    int mzl;
    int mcnt;
    int idx;
    int pos;
    bit poked;
    mzl = tz; mcnt = nr; idx = 0; pos = 0; poked = 0;
    @(negedge clk);
    start = 1'b1; tz_i = 4'(tz); nr_i = 4'(nr); out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    while (mcnt > 0) begin
      int g;
      int z;
      int eb;
      int er [3];
      string vtag;
      win = stream[127 - pos -: 11];           // R10: first unread bit at MSB
      out_ready = ($urandom % 4) != 0;
      start = noise && (($urandom % 6) == 0);
      tz_i = 4'($urandom); nr_i = 4'($urandom);
      #1;
      g = (mzl <= 6) ? ((mcnt < 3) ? mcnt : 3) : 1;
      z = mzl; eb = 0;
      vtag = poked ? "R1" : ((mzl > 6) ? "R3" : "R2");
      chk(out_valid == 1'b1, "R8", "out_valid during block", int'(out_valid), 1);
      chk(int'(run_vld) == (1 << g) - 1, vtag, "run_vld", int'(run_vld), (1 << g) - 1);
      for (int k = 0; k < g; k++) begin
        string rtag;
        er[k] = drn[idx + k];
        rtag = (z == 0) ? "R7" : ((mzl > 6) ? "R3" : "R4");
        chk(int'(run_vals[4*k +: 4]) == er[k], rtag, "run lane", int'(run_vals[4*k +: 4]), er[k]);
        if (z > 0) eb += enc_len(z, er[k]);
        z -= er[k];
      end
      chk(int'(bits_used) == eb, bits_tag, "bits_used", int'(bits_used), eb);
      poked = start;
      if (out_ready) begin
        mzl = z; mcnt -= g; idx += g; pos += eb;
      end
      @(negedge clk);
      start = 1'b0;
    end
    out_ready = 1'b0;
    #1;
    chk(done == 1'b1, "R9", "done after last step", int'(done), 1);
    chk(out_valid == 1'b0, "R9", "out_valid after last step", int'(out_valid), 0);
    @(negedge clk);
    #1;
    chk(done == 1'b0, "R9", "done one cycle only", int'(done), 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R8", "reset out_valid", int'(out_valid), 0);
    chk(done == 1'b0, "R9", "reset done", int'(done), 0);
    chk(run_vld == 3'b000, "R2", "reset run_vld", int'(run_vld), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // zero budget 4, runs 1,2,0 in one step then 1 more
    drn[0] = 1; drn[1] = 2; drn[2] = 0; drn[3] = 1;
    build(4, 4, 1'b0);
    run_block(4, 4, "R5", 1'b0);

    // three-symbol case 1,2,3 uses 8 bits
    drn[0] = 1; drn[1] = 2; drn[2] = 3;
    build(6, 3, 1'b0);
    run_block(6, 3, "R5", 1'b0);

    // leading-zero case: two symbols 1,2 use 6 bits; vary the garbage after
    for (int r = 0; r < 4; r++) begin
      drn[0] = 1; drn[1] = 2;
      build(6, 2, 1'b0);
      run_block(6, 2, "R6", 1'b0);
    end

    // single-symbol garbage immunity beyond 3 bits
    for (int r = 0; r < 3; r++) begin
      drn[0] = 3;
      build(5, 1, 1'b0);
      run_block(5, 1, "R6", 1'b0);
    end

    // budget exhausted early: later runs read 0 with no bits
    drn[0] = 2; drn[1] = 0; drn[2] = 0; drn[3] = 0; drn[4] = 0;
    build(2, 5, 1'b0);
    run_block(2, 5, "R7", 1'b0);

    // long codes down to 14
    drn[0] = 14; drn[1] = 0;
    build(14, 2, 1'b0);
    run_block(14, 2, "R3", 1'b0);
    drn[0] = 7; drn[1] = 2; drn[2] = 3;
    build(12, 3, 1'b0);
    run_block(12, 3, "R3", 1'b0);

    // no symbols: done right after start
    @(negedge clk);
    start = 1'b1; tz_i = 4'd5; nr_i = 4'd0;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(done == 1'b1, "R9", "done with zero symbols", int'(done), 1);
    chk(out_valid == 1'b0, "R9", "no step with zero symbols", int'(out_valid), 0);

    // random blocks with back-pressure and ignored start pulses
    for (int b = 0; b < 400; b++) begin
      int tz;
      int nr;
      tz = (b % 3 == 0) ? int'($urandom % 16) : int'($urandom % 7);
      nr = 1 + int'($urandom % 15);
      build(tz, nr, 1'b1);
      run_block(tz, nr, "R5", 1'b1);
    end

    summary();
    $finish;
  end
endmodule